// File: doc/BRIEF.md
# Edge-Selectable Interrupt Aggregator

This block collects a vector of single-bit interrupt sources and folds them into two requests for a processor core: a high-priority request and a low-priority request. For each source, software picks which edge triggers it: rising, falling, both, or none. Software also picks which of the two requests the source feeds. The sources must already be synchronous to the block clock.

A detected edge sets a pending bit for that source. Each core request is high while any pending bit routed to it is set. The interrupt service routine for a priority reads that priority's status word to learn which sources need attention. The read also clears those pending bits.

A parameter mask marks some lines as rising-edge-only. A second parameter names one line as level-following: its pending bit is not cleared by a read and drops by itself once the input goes low.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all enable, priority and pending bits are zero. Both requests are low and every register word reads as zero.
- R2: The bus uses word addresses 0 (rise enables), 1 (fall enables), 2 (priority select), 3 (high status) and 4 (low status). A write to address 0, 1 or 2 stores the data. Writes to any other address have no effect. Read data appears on `bus_rdata_o` one cycle after the read strobe. Unused addresses read zero.
- R3: A rising edge on line i, with bit i of the rise enables set, sets pending bit i.
- R4: A falling edge on line i, with bit i of the fall enables set, sets pending bit i. This holds only when line i is not rising-edge-only. An edge whose enable bit is clear sets nothing.
- R5: On lines marked in `RISE_ONLY_MASK` (bits 22 to 31 by default), the fall enable bit has no effect.
- R6: Priority bit i = 1 routes line i to the high status word (address 3) and the high request. Priority bit i = 0 routes it to the low status word (address 4) and the low request. Bit i of a status word is pending bit i.
- R7: `irq_hi_o` is the OR of the pending bits routed high. `irq_lo_o` is the OR of the pending bits routed low.
- R8: A read of one status word clears the pending bits routed to that priority. It leaves the other priority's bits untouched.
- R9: An enabled edge in the same cycle as a clearing read leaves the pending bit set.
- R10: Line `LEVEL_IDX` (31 by default) is never cleared by a read. Its pending bit clears in the cycle after its input is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_i | input | NUM_LINES | Interrupt sources, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Read data, valid the cycle after the read strobe |
| irq_hi_o | output | 1 | High-priority core request |
| irq_lo_o | output | 1 | Low-priority core request |

## Verification
A source edge presented before clock edge k is latched at edge k. Both requests reflect it right after that edge, so the bench drives inputs on falling clock edges and samples the requests half a cycle after the next rising edge. A read strobe is captured at edge k, and the status word and the clear both take effect after edge k. The bench therefore compares `bus_rdata_o` and the requests at the following falling edge. This includes the concurrent edge-and-read case and the level line, which needs one edge after its input falls.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_RISE    = 3'd0;
  localparam logic [ADDR_W-1:0] A_FALL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRIO    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 3'd4;
endpackage

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rise_en_o,
  output logic [NUM_LINES-1:0] fall_en_o,
  output logic [NUM_LINES-1:0] prio_o
);
  logic rise_we, fall_we, prio_we;
  logic [NUM_LINES-1:0] rise_q, fall_q, prio_q;

  // write enables decoded separately from the storage
  always_comb begin
    rise_we = wr_i && (addr_i == A_RISE);
    fall_we = wr_i && (addr_i == A_FALL);
    prio_we = wr_i && (addr_i == A_PRIO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      prio_q <= '0;
    end else begin
      if (rise_we) rise_q <= wdata_i;
      if (fall_we) fall_q <= wdata_i;
      if (prio_we) prio_q <= wdata_i;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign prio_o    = prio_q;
endmodule

// File: rtl/irq_agg_edge.sv
module irq_agg_edge #(
  parameter int                   NUM_LINES      = 32,
  parameter logic [NUM_LINES-1:0] RISE_ONLY_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic [NUM_LINES-1:0] rise_en_i,
  input  logic [NUM_LINES-1:0] fall_en_i,
  output logic [NUM_LINES-1:0] prev_o,
  output logic [NUM_LINES-1:0] event_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise_w, fall_w, fall_ok;

  always_comb begin
    rise_w  = src_i & ~prev_q;
    fall_w  = ~src_i & prev_q;
    // falling detection masked off on rising-only lines
    fall_ok = fall_en_i & ~RISE_ONLY_MASK;
    event_o = (rise_w & rise_en_i) | (fall_w & fall_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
  parameter int NUM_LINES = 32,
  parameter int LEVEL_IDX = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] event_i,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic [NUM_LINES-1:0] prio_i,
  input  logic                 clr_hi_i,
  input  logic                 clr_lo_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic nxt;
    if (g == LEVEL_IDX) begin : g_level
      // level-following line: reads never clear it, a low input does
      always_comb begin
        if (event_i[g])     nxt = 1'b1;
        else if (!src_i[g]) nxt = 1'b0;
        else                nxt = pend_q[g];
      end
    end else begin : g_edge
      logic clr;
      always_comb begin
        clr = prio_i[g] ? clr_hi_i : clr_lo_i;
        if (event_i[g]) nxt = 1'b1;      // new event beats a clearing read
        else if (clr)   nxt = 1'b0;
        else            nxt = pend_q[g];
      end
    end
    assign pend_d[g] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_agg_rd.sv
module irq_agg_rd
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] rise_en_i,
  input  logic [NUM_LINES-1:0] fall_en_i,
  input  logic [NUM_LINES-1:0] prio_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 clr_hi_o,
  output logic                 clr_lo_o
);
  logic [NUM_LINES-1:0] rdata_d, rdata_q;

  always_comb begin
    unique case (addr_i)
      A_RISE:    rdata_d = rise_en_i;
      A_FALL:    rdata_d = fall_en_i;
      A_PRIO:    rdata_d = prio_i;
      A_STAT_HI: rdata_d = pend_i & prio_i;
      A_STAT_LO: rdata_d = pend_i & ~prio_i;
      default:   rdata_d = '0;
    endcase
    clr_hi_o = rd_i && (addr_i == A_STAT_HI);
    clr_lo_o = rd_i && (addr_i == A_STAT_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES      = 32,
  parameter logic [NUM_LINES-1:0] RISE_ONLY_MASK = {{10{1'b1}}, {(NUM_LINES-10){1'b0}}},
  parameter int                   LEVEL_IDX      = NUM_LINES - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  output logic [NUM_LINES-1:0] bus_rdata_o,
  output logic                 irq_hi_o,
  output logic                 irq_lo_o
);
  logic [NUM_LINES-1:0] rise_en, fall_en, prio;
  logic [NUM_LINES-1:0] src_q, event_w, pend;
  logic                 clr_hi, clr_lo;

  irq_agg_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .prio_o(prio)
  );

  irq_agg_edge #(.NUM_LINES(NUM_LINES), .RISE_ONLY_MASK(RISE_ONLY_MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_en_i(rise_en),
    .fall_en_i(fall_en), .prev_o(src_q), .event_o(event_w)
  );

  irq_agg_pend #(.NUM_LINES(NUM_LINES), .LEVEL_IDX(LEVEL_IDX)) u_pend (
    .clk(clk), .rst_n(rst_n), .event_i(event_w), .src_i(src_i),
    .prio_i(prio), .clr_hi_i(clr_hi), .clr_lo_i(clr_lo), .pend_o(pend)
  );

  irq_agg_rd #(.NUM_LINES(NUM_LINES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .prio_i(prio), .pend_i(pend),
    .rdata_o(bus_rdata_o), .clr_hi_o(clr_hi), .clr_lo_o(clr_lo)
  );

  assign irq_hi_o = |(pend & prio);
  assign irq_lo_o = |(pend & ~prio);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES      = 32,
  parameter logic [NUM_LINES-1:0] RISE_ONLY_MASK = '0,
  parameter int                   LEVEL_IDX      = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] src_i,
  input logic                 bus_wr_i,
  input logic                 bus_rd_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [NUM_LINES-1:0] bus_rdata_o,
  input logic                 irq_hi_o,
  input logic                 irq_lo_o,
  input logic [NUM_LINES-1:0] rise_en,
  input logic [NUM_LINES-1:0] prio,
  input logic [NUM_LINES-1:0] src_q,
  input logic [NUM_LINES-1:0] event_w,
  input logic [NUM_LINES-1:0] pend
);
  localparam logic [NUM_LINES-1:0] LVL_MASK =
    (LEVEL_IDX >= 0 && LEVEL_IDX < NUM_LINES) ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << LEVEL_IDX) : '0;

  assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && bus_addr_i == A_RISE) |=> (bus_rdata_o == $past(rise_en)));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!irq_hi_o && !irq_lo_o));

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & ~src_q & rise_en)) |=> (irq_hi_o || irq_lo_o));

  assert_riseonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_w & RISE_ONLY_MASK & ~src_i) == '0));

  assert_hi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && bus_addr_i == A_STAT_HI && event_w == '0)
    |=> ((pend & prio & ~LVL_MASK) == '0));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_w) |=> ((pend & $past(event_w)) == $past(event_w)));

  if (LEVEL_IDX >= 0 && LEVEL_IDX < NUM_LINES) begin : g_lvl
    assert_level_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !src_i[LEVEL_IDX] |=> !pend[LEVEL_IDX]);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .RISE_ONLY_MASK(RISE_ONLY_MASK), .LEVEL_IDX(LEVEL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .rise_en(rise_en), .prio(prio),
  .src_q(src_q), .event_w(event_w), .pend(pend)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int          N   = 32;
  localparam int          LVL = 31;
  localparam logic [31:0] RO  = 32'hFFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        wr, rd;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_hi, irq_lo;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick();
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_hi", {31'b0, irq_hi}, 32'd0);
    check("R1 irq_lo", {31'b0, irq_lo}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      bus_rd(3'(a), d);
      check("R1 reset read", d, 32'd0);
    end

    // R2: config write and readback, dead addresses
    bus_wr(3'd0, 32'hA5A5_1234);
    bus_wr(3'd1, 32'h0F0F_F0F0);
    bus_wr(3'd2, 32'h1357_9BDF);
    bus_rd(3'd0, d); check("R2 rise", d, 32'hA5A5_1234);
    bus_rd(3'd1, d); check("R2 fall", d, 32'h0F0F_F0F0);
    bus_rd(3'd2, d); check("R2 prio", d, 32'h1357_9BDF);
    bus_wr(3'd3, 32'hFFFF_FFFF);
    bus_wr(3'd4, 32'hFFFF_FFFF);
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_rd(3'd3, d); check("R2 stat hi untouched", d, 32'd0);
    bus_rd(3'd4, d); check("R2 stat lo untouched", d, 32'd0);
    bus_rd(3'd6, d); check("R2 unused addr", d, 32'd0);
    bus_rd(3'd0, d); check("R2 rise after dead writes", d, 32'hA5A5_1234);
    bus_wr(3'd0, 0); bus_wr(3'd1, 0); bus_wr(3'd2, 0);

    // Sweep: every line, every rise/fall/priority combination
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic re, fe, pr, lv, ro, expf;
        logic [2:0] sa, oa;
        re = c[0]; fe = c[1]; pr = c[2];
        lv = (i == LVL); ro = RO[i];
        expf = fe && !ro;
        sa = pr ? 3'd3 : 3'd4;
        oa = pr ? 3'd4 : 3'd3;
        bus_wr(3'd0, 32'(re) << i);
        bus_wr(3'd1, 32'(fe) << i);
        bus_wr(3'd2, 32'(pr) << i);
        src[i] = 1'b1;
        tick();
        check("R3 R7 irq_hi after rise", {31'b0, irq_hi}, {31'b0, pr & re});
        check("R3 R7 irq_lo after rise", {31'b0, irq_lo}, {31'b0, !pr & re});
        bus_rd(sa, d);
        check("R6 status after rise", d, 32'(re) << i);
        bus_rd(oa, d);
        check("R8 other status", d, 32'd0);
        check("R8 R10 irq after read", {30'b0, irq_hi, irq_lo},
              {30'b0, pr & re & lv, !pr & re & lv});
        src[i] = 1'b0;
        tick();
        if (ro) check("R5 irq after fall (rise-only)", {30'b0, irq_hi, irq_lo}, 32'd0);
        else    check("R4 irq after fall", {30'b0, irq_hi, irq_lo}, {30'b0, pr & expf, !pr & expf});
        bus_rd(sa, d);
        check(ro ? "R5 status after fall" : "R4 status after fall", d, 32'(expf) << i);
        check("R8 irq cleared", {30'b0, irq_hi, irq_lo}, 32'd0);
      end
    end
    bus_wr(3'd0, 0); bus_wr(3'd1, 0); bus_wr(3'd2, 0);

    // R8: two priorities cleared independently
    bus_wr(3'd0, 32'h6); bus_wr(3'd2, 32'h2);
    src[1] = 1'b1; src[2] = 1'b1;
    tick();
    bus_rd(3'd3, d); check("R8 hi status", d, 32'h2);
    check("R8 hi cleared lo kept", {30'b0, irq_hi, irq_lo}, 32'h1);
    bus_rd(3'd4, d); check("R8 lo status", d, 32'h4);
    check("R8 both clear", {30'b0, irq_hi, irq_lo}, 32'h0);
    src[1] = 1'b0; src[2] = 1'b0;
    tick();

    // R9: edge in the same cycle as a clearing read
    bus_wr(3'd0, 32'h1); bus_wr(3'd2, 32'h1);
    src[0] = 1'b1; tick();
    src[0] = 1'b0; tick();
    src[0] = 1'b1; rd = 1'b1; addr = 3'd3;
    tick();
    rd = 1'b0;
    check("R9 rdata", rdata, 32'h1);
    check("R9 event kept", {31'b0, irq_hi}, 32'h1);
    bus_rd(3'd3, d); check("R9 second read", d, 32'h1);
    check("R9 cleared later", {31'b0, irq_hi}, 32'h0);
    src[0] = 1'b0; tick();

    // R10: level-following line
    bus_wr(3'd0, 32'h8000_0000); bus_wr(3'd2, 32'h0);
    src[31] = 1'b1; tick();
    bus_rd(3'd4, d); check("R10 first read", d, 32'h8000_0000);
    check("R10 kept after read", {31'b0, irq_lo}, 32'h1);
    bus_rd(3'd4, d); check("R10 second read", d, 32'h8000_0000);
    src[31] = 1'b0; tick();
    check("R10 drops with input", {31'b0, irq_lo}, 32'h0);
    bus_rd(3'd4, d); check("R10 status after drop", d, 32'h0);

    summary();
    $finish;
  end
endmodule